// File: doc/BRIEF.md
# Timekeeper Presence Probe and Startup Sequencer

This block brings up an external serial timekeeper after power-on. A single start request sets off a fixed series of register accesses over a three-wire serial link: a chip enable, a shift clock and one bidirectional data line, which is brought out as separate output, output-enable and input pins. The serial engine that shifts the bytes is part of the block. Every access is one framed transaction. The block raises chip enable, sends a command byte and then sends or receives one data byte, least significant bit first. It drops chip enable and waits a guard gap before the next access.

The routine first tests whether the device is there. It lifts write protection, stores a magic byte in scratch RAM location 0 and reads that location back. If the byte returned differs, the block stops, reports the device as absent and pulses done. If the byte matches, the block restores write protection. It then programs the trickle-charge register with a fixed upper nibble and a 4-bit selection taken from an input. Last, it reads the seconds register and writes the value back with the clock-halt bit (bit 7) cleared, which starts the oscillator. Each register write is wrapped in its own protection unlock and relock.

Top module: `rtc_boot`

## Requirements
- R1: While reset is held, and after it until a start request, chip enable, shift clock and data output enable are low, and busy, done and present are 0.
- R2: Each access holds chip enable high for exactly 16 shift-clock rising edges: 8 for the command and 8 for the data. Written bits are driven least significant first and change only while the shift clock is low. Chip enable changes only while the shift clock is low.
- R3: A run starts with three accesses in this order: write command 0x8E with data 0x00, then write command 0xC0 with data 0x42, then read command 0xC1. Bit 0 of a command is 1 for a read and 0 for a write.
- R4: If the byte read with 0xC1 differs from 0x42 in any bit, the run ends after exactly those three accesses, with present 0.
- R5: On a match, the fourth access writes command 0x8E with data 0x80.
- R6: Accesses five to seven are 0x8E/0x00, then command 0x90 with data {TRICKLE_HI, sel}, then 0x8E/0x80. TRICKLE_HI defaults to 4'hA, and sel is the 4-bit selection captured at start.
- R7: Accesses eight to eleven are read command 0x81, then 0x8E/0x00, then command 0x80 with the seconds byte that was read and its bit 7 forced to 0, then 0x8E/0x80. A run with a present device makes exactly eleven accesses.
- R8: Each run ends with done high for exactly one clock, in the same cycle that busy falls. present takes the result of the run in that cycle.
- R9: A start request while busy is high is ignored. It neither restarts nor lengthens the run, and it adds no done pulse.
- R10: A read byte is taken least significant bit first, one bit while the shift clock is low before each of the 8 rising edges that follow the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request; sampled while idle |
| trickle_sel_i | input | 4 | Low nibble for the trickle-charge register |
| rtc_ce_o | output | 1 | Serial chip enable, high during an access |
| rtc_sclk_o | output | 1 | Serial shift clock |
| rtc_io_o | output | 1 | Serial data out |
| rtc_io_oe_o | output | 1 | Drive enable for serial data |
| rtc_io_i | input | 1 | Serial data in |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| present_o | output | 1 | Device found in the last completed run |

## Verification
The hardest situation to reach from the ports is a read-back that is wrong in only one bit. A single bit at either end of the byte must still end the run as absent, and an ordinary device never returns such a byte. The bench device model therefore XORs a chosen mask into the scratch byte it returns: directed masks 0x01 and 0x80, plus random nonzero masks. A start request is also injected in the middle of a running sequence. Seconds values with bit 7 set and clear show that only that one bit is changed in the write-back.

// File: rtl/rtc_boot_pkg.sv
// Package: shared types and command codes for the timekeeper startup block.
// Assumes the device decodes bit 0 of a command as read (1) / write (0).
package rtc_boot_pkg;

    // One serial access: direction, command byte, data byte for writes
    typedef struct packed {
        logic       rd;
        logic [7:0] cmd;
        logic [7:0] wdat;
    } xfer_t;

    localparam logic [7:0] CMD_CTRL_WR = 8'h8E;
    localparam logic [7:0] CMD_RAM0_WR = 8'hC0;
    localparam logic [7:0] CMD_RAM0_RD = 8'hC1;
    localparam logic [7:0] CMD_TCS_WR  = 8'h90;
    localparam logic [7:0] CMD_SEC_RD  = 8'h81;
    localparam logic [7:0] CMD_SEC_WR  = 8'h80;
    localparam logic [7:0] WP_OFF      = 8'h00;
    localparam logic [7:0] WP_ON       = 8'h80;

    localparam int unsigned NUM_STEPS   = 11;
    localparam int unsigned STEP_W      = $clog2(NUM_STEPS);
    localparam int unsigned STEP_PROBE  = 2;
    localparam int unsigned STEP_SECRD  = 7;

    typedef enum logic [2:0] {
        L_IDLE, L_SETUP, L_CMD, L_DATA, L_HOLD, L_GAP
    } link_st_t;

    typedef enum logic [1:0] {
        Q_IDLE, Q_ISSUE, Q_WAIT
    } seq_st_t;

endpackage

// File: rtl/rtc_boot_shifter.sv
// Byte shifter: moves one byte LSB first over the serial clock/data pins.
// Write: data set while the clock is low, device latches on the rise.
// Read: a bit is sampled at the end of each low phase.
// Assumes go_i is pulsed only while idle; HALF_CYC >= 1 clocks per phase.
module rtc_boot_shifter #(
    parameter int unsigned HALF_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic       dir_out_i,
    input  logic [7:0] byte_i,
    input  logic       dat_i,
    output logic       sclk_o,
    output logic       dat_o,
    output logic       oe_o,
    output logic [7:0] byte_o,
    output logic       fin_o
);
    localparam int unsigned CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HALF_CYC - 1);

    logic          active_q;
    logic          phase_q;
    logic          dir_q;
    logic [2:0]    idx_q;
    logic [CW-1:0] cnt_q;
    logic [7:0]    sh_q;
    logic          fin_q;
    logic          tick;

    assign tick = (cnt_q == CNT_LAST);

    // Phase timing, bit counting and shift register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            phase_q  <= 1'b0;
            dir_q    <= 1'b0;
            idx_q    <= '0;
            cnt_q    <= '0;
            sh_q     <= '0;
            fin_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go_i) begin
                active_q <= 1'b1;
                phase_q  <= 1'b0;
                dir_q    <= dir_out_i;
                idx_q    <= '0;
                cnt_q    <= '0;
                sh_q     <= byte_i;
            end else if (active_q) begin
                if (tick) begin
                    cnt_q <= '0;
                    if (!phase_q) begin
                        phase_q <= 1'b1;
                        if (!dir_q) begin
                            sh_q <= {dat_i, sh_q[7:1]};
                        end
                    end else begin
                        phase_q <= 1'b0;
                        if (dir_q) begin
                            sh_q <= {1'b0, sh_q[7:1]};
                        end
                        if (idx_q == 3'd7) begin
                            active_q <= 1'b0;
                            fin_q    <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 3'd1;
                        end
                    end
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
            end
        end
    end

    assign sclk_o = active_q & phase_q;
    assign oe_o   = active_q & dir_q;
    assign dat_o  = active_q & dir_q & sh_q[0];
    assign byte_o = sh_q;
    assign fin_o  = fin_q;

endmodule

// File: rtl/rtc_boot_link.sv
// Access framer: runs one command byte and one data byte inside a chip
// enable window, with a setup guard, a hold guard and an idle gap.
// Assumes req_i is pulsed only when the previous access has been acked.
module rtc_boot_link
    import rtc_boot_pkg::*;
#(
    parameter int unsigned HALF_CYC  = 2,
    parameter int unsigned GUARD_CYC = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  xfer_t      xfer_i,
    output logic       ack_o,
    output logic [7:0] rdata_o,
    output logic       ce_o,
    output logic       sclk_o,
    output logic       dat_o,
    output logic       oe_o,
    input  logic       dat_i
);
    localparam int unsigned GW = (GUARD_CYC > 1) ? $clog2(GUARD_CYC) : 1;
    localparam logic [GW-1:0] G_LAST = GW'(GUARD_CYC - 1);

    link_st_t      st_q;
    xfer_t         xfer_q;
    logic [GW-1:0] gcnt_q;
    logic          gdone;
    logic          ack_q;
    logic [7:0]    rdata_q;
    logic          go;
    logic          dir_out;
    logic [7:0]    sh_byte;
    logic [7:0]    sh_rx;
    logic          sh_fin;

    assign gdone = (gcnt_q == G_LAST);

    // Start the shifter at the end of setup and after the command byte
    always_comb begin
        go      = ((st_q == L_SETUP) && gdone) || ((st_q == L_CMD) && sh_fin);
        dir_out = (st_q == L_SETUP) ? 1'b1 : !xfer_q.rd;
        sh_byte = (st_q == L_SETUP) ? xfer_q.cmd : xfer_q.wdat;
    end

    // Access framing state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= L_IDLE;
            xfer_q  <= '0;
            gcnt_q  <= '0;
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q <= 1'b0;
            unique case (st_q)
                L_IDLE: begin
                    if (req_i) begin
                        xfer_q <= xfer_i;
                        gcnt_q <= '0;
                        st_q   <= L_SETUP;
                    end
                end
                L_SETUP: begin
                    if (gdone) st_q <= L_CMD;
                    else       gcnt_q <= gcnt_q + GW'(1);
                end
                L_CMD: begin
                    if (sh_fin) st_q <= L_DATA;
                end
                L_DATA: begin
                    if (sh_fin) begin
                        rdata_q <= sh_rx;
                        gcnt_q  <= '0;
                        st_q    <= L_HOLD;
                    end
                end
                L_HOLD: begin
                    if (gdone) begin
                        gcnt_q <= '0;
                        st_q   <= L_GAP;
                    end else begin
                        gcnt_q <= gcnt_q + GW'(1);
                    end
                end
                L_GAP: begin
                    if (gdone) begin
                        ack_q <= 1'b1;
                        st_q  <= L_IDLE;
                    end else begin
                        gcnt_q <= gcnt_q + GW'(1);
                    end
                end
                default: st_q <= L_IDLE;
            endcase
        end
    end

    rtc_boot_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (go),
        .dir_out_i (dir_out),
        .byte_i    (sh_byte),
        .dat_i     (dat_i),
        .sclk_o    (sclk_o),
        .dat_o     (dat_o),
        .oe_o      (oe_o),
        .byte_o    (sh_rx),
        .fin_o     (sh_fin)
    );

    assign ce_o    = (st_q == L_SETUP) || (st_q == L_CMD) ||
                     (st_q == L_DATA)  || (st_q == L_HOLD);
    assign ack_o   = ack_q;
    assign rdata_o = rdata_q;

endmodule

// File: rtl/rtc_boot_seq.sv
// Startup sequencer: steps through the probe, trickle and clock-start
// accesses. It stops early when the scratch read-back differs from MAGIC.
// Assumes ack_i arrives once per req_o and rdata_i is valid with it.
module rtc_boot_seq
    import rtc_boot_pkg::*;
#(
    parameter logic [3:0] TRICKLE_HI = 4'hA,
    parameter logic [7:0] MAGIC      = 8'h42
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [3:0] sel_i,
    output logic       req_o,
    output xfer_t      xfer_o,
    input  logic       ack_i,
    input  logic [7:0] rdata_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       present_o
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
    localparam logic [STEP_W-1:0] PROBE_RD  = STEP_W'(STEP_PROBE);
    localparam logic [STEP_W-1:0] SEC_RD    = STEP_W'(STEP_SECRD);

    seq_st_t           st_q;
    logic [STEP_W-1:0] step_q;
    logic [3:0]        sel_q;
    logic [7:0]        sec_q;
    logic              busy_q;
    logic              done_q;
    logic              present_q;

    // Access for a given step of the startup routine
    function automatic xfer_t step_xfer(input logic [STEP_W-1:0] s,
                                        input logic [3:0] sel,
                                        input logic [7:0] sec);
        xfer_t x;
        x = '{rd: 1'b0, cmd: CMD_CTRL_WR, wdat: WP_OFF};
        case (s)
            STEP_W'(1):  x = '{rd: 1'b0, cmd: CMD_RAM0_WR, wdat: MAGIC};
            STEP_W'(2):  x = '{rd: 1'b1, cmd: CMD_RAM0_RD, wdat: 8'h00};
            STEP_W'(3):  x = '{rd: 1'b0, cmd: CMD_CTRL_WR, wdat: WP_ON};
            STEP_W'(5):  x = '{rd: 1'b0, cmd: CMD_TCS_WR,  wdat: {TRICKLE_HI, sel}};
            STEP_W'(6):  x = '{rd: 1'b0, cmd: CMD_CTRL_WR, wdat: WP_ON};
            STEP_W'(7):  x = '{rd: 1'b1, cmd: CMD_SEC_RD,  wdat: 8'h00};
            STEP_W'(9):  x = '{rd: 1'b0, cmd: CMD_SEC_WR,  wdat: {1'b0, sec[6:0]}};
            STEP_W'(10): x = '{rd: 1'b0, cmd: CMD_CTRL_WR, wdat: WP_ON};
            default:     x = '{rd: 1'b0, cmd: CMD_CTRL_WR, wdat: WP_OFF};
        endcase
        return x;
    endfunction

    // Step control and result reporting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= Q_IDLE;
            step_q    <= '0;
            sel_q     <= '0;
            sec_q     <= '0;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            present_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st_q)
                Q_IDLE: begin
                    if (start_i) begin
                        step_q <= '0;
                        sel_q  <= sel_i;
                        busy_q <= 1'b1;
                        st_q   <= Q_ISSUE;
                    end
                end
                Q_ISSUE: st_q <= Q_WAIT;
                Q_WAIT: begin
                    if (ack_i) begin
                        if (step_q == PROBE_RD && rdata_i != MAGIC) begin
                            busy_q    <= 1'b0;
                            done_q    <= 1'b1;
                            present_q <= 1'b0;
                            st_q      <= Q_IDLE;
                        end else if (step_q == LAST_STEP) begin
                            busy_q    <= 1'b0;
                            done_q    <= 1'b1;
                            present_q <= 1'b1;
                            st_q      <= Q_IDLE;
                        end else begin
                            if (step_q == SEC_RD) sec_q <= rdata_i;
                            step_q <= step_q + STEP_W'(1);
                            st_q   <= Q_ISSUE;
                        end
                    end
                end
                default: st_q <= Q_IDLE;
            endcase
        end
    end

    assign req_o     = (st_q == Q_ISSUE);
    assign xfer_o    = step_xfer(step_q, sel_q, sec_q);
    assign busy_o    = busy_q;
    assign done_o    = done_q;
    assign present_o = present_q;

endmodule

// File: rtl/rtc_boot.sv
// Top: timekeeper presence probe and startup sequencer over a three-wire
// serial link. Assumes the device drives data only while output enable is low.
module rtc_boot
    import rtc_boot_pkg::*;
#(
    parameter int unsigned HALF_CYC   = 2,
    parameter int unsigned GUARD_CYC  = 3,
    parameter logic [3:0]  TRICKLE_HI = 4'hA,
    parameter logic [7:0]  MAGIC      = 8'h42
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic [3:0] trickle_sel_i,
    output logic       rtc_ce_o,
    output logic       rtc_sclk_o,
    output logic       rtc_io_o,
    output logic       rtc_io_oe_o,
    input  logic       rtc_io_i,
    output logic       busy_o,
    output logic       done_o,
    output logic       present_o
);
    logic       req;
    xfer_t      xfer;
    logic       ack;
    logic [7:0] rdata;

    rtc_boot_seq #(.TRICKLE_HI(TRICKLE_HI), .MAGIC(MAGIC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .sel_i     (trickle_sel_i),
        .req_o     (req),
        .xfer_o    (xfer),
        .ack_i     (ack),
        .rdata_i   (rdata),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .present_o (present_o)
    );

    rtc_boot_link #(.HALF_CYC(HALF_CYC), .GUARD_CYC(GUARD_CYC)) u_link (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req),
        .xfer_i  (xfer),
        .ack_o   (ack),
        .rdata_o (rdata),
        .ce_o    (rtc_ce_o),
        .sclk_o  (rtc_sclk_o),
        .dat_o   (rtc_io_o),
        .oe_o    (rtc_io_oe_o),
        .dat_i   (rtc_io_i)
    );

endmodule

// File: rtl/rtc_boot_chk.sv
// Checker: protocol and handshake properties of rtc_boot, bound to the top.
module rtc_boot_chk (
    input logic clk,
    input logic rst_n,
    input logic rtc_ce_o,
    input logic rtc_sclk_o,
    input logic rtc_io_o,
    input logic rtc_io_oe_o,
    input logic busy_o,
    input logic done_o
);
    // R1: no serial activity while no run is in progress
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rtc_ce_o && !rtc_sclk_o && !rtc_io_oe_o));

    // R2: shift clock pulses only inside the chip enable window
    a_r2_sclk_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_sclk_o |-> rtc_ce_o);

    // R2: data is driven only inside the chip enable window
    a_r2_oe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_io_oe_o |-> rtc_ce_o);

    // R2: written data does not move while the shift clock is high
    a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rtc_sclk_o |-> $stable(rtc_io_o));

    // R2: chip enable toggles only with the shift clock low
    a_r2_ce_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rtc_ce_o) |-> !rtc_sclk_o);

    // R8: done lasts one clock
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: done comes with busy low, and busy falls only with done
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    a_r8_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

endmodule

bind rtc_boot rtc_boot_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rtc_ce_o    (rtc_ce_o),
    .rtc_sclk_o  (rtc_sclk_o),
    .rtc_io_o    (rtc_io_o),
    .rtc_io_oe_o (rtc_io_oe_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/rtc_boot_tb.sv
// Bench: device model on the serial pins, directed and seeded random runs.
module rtc_boot_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [3:0] sel = 4'h0;
    logic       ce, sclk, dout, doe, din;
    logic       busy, done, present;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rtc_boot u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start_i),
        .trickle_sel_i (sel),
        .rtc_ce_o      (ce),
        .rtc_sclk_o    (sclk),
        .rtc_io_o      (dout),
        .rtc_io_oe_o   (doe),
        .rtc_io_i      (din),
        .busy_o        (busy),
        .done_o        (done),
        .present_o     (present)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0] m_cmd = 8'h00, m_dat = 8'h00, m_ram0 = 8'h00;
    logic [7:0] m_sec = 8'h00, m_mask = 8'h00, m_rbyte;
    int         m_bits = 0;
    logic [7:0] log_cmd [0:31];
    logic [7:0] log_dat [0:31];
    int         log_n = 0;
    int         done_cnt = 0;

    always_comb begin
        if (m_cmd == 8'hC1)      m_rbyte = m_ram0 ^ m_mask;
        else if (m_cmd == 8'h81) m_rbyte = m_sec;
        else                     m_rbyte = 8'h00;
    end
    assign din = (m_bits >= 8 && m_bits < 16 && m_cmd[0]) ? m_rbyte[3'(m_bits - 8)] : 1'b0;

    always @(posedge ce) begin
        m_bits = 0;
        m_cmd  = 8'h00;
        m_dat  = 8'h00;
    end
    always @(posedge sclk) begin
        if (m_bits < 8) m_cmd[3'(m_bits)] = dout;
        else if (m_bits < 16 && !m_cmd[0]) m_dat[3'(m_bits - 8)] = dout;
        m_bits++;
    end
    always @(negedge ce) begin
        chk(m_bits == 16, "R2", "clock edges per access", m_bits, 16);
        if (log_n < 32) begin
            log_cmd[log_n] = m_cmd;
            log_dat[log_n] = m_cmd[0] ? m_rbyte : m_dat;
        end
        if (m_cmd == 8'hC0) m_ram0 = m_dat;
        log_n++;
    end
    always @(negedge clk) if (done) done_cnt++;

    // ---------------- expected sequence ----------------
    logic [7:0] e_cmd [0:10];
    logic [7:0] e_dat [0:10];
    int         e_n;

    function automatic string tag_of(input int i);
        if (i < 3)  return "R3";
        if (i == 3) return "R5";
        if (i < 7)  return "R6";
        if (i == 9) return "R7/R10";
        return "R7";
    endfunction

    task automatic build_exp(input logic [3:0] s, input logic [7:0] sec,
                             input logic [7:0] mask);
        e_cmd[0] = 8'h8E; e_dat[0] = 8'h00;
        e_cmd[1] = 8'hC0; e_dat[1] = 8'h42;
        e_cmd[2] = 8'hC1; e_dat[2] = 8'h42 ^ mask;
        e_cmd[3] = 8'h8E; e_dat[3] = 8'h80;
        e_cmd[4] = 8'h8E; e_dat[4] = 8'h00;
        e_cmd[5] = 8'h90; e_dat[5] = {4'hA, s};
        e_cmd[6] = 8'h8E; e_dat[6] = 8'h80;
        e_cmd[7] = 8'h81; e_dat[7] = sec;
        e_cmd[8] = 8'h8E; e_dat[8] = 8'h00;
        e_cmd[9] = 8'h80; e_dat[9] = sec & 8'h7F;
        e_cmd[10] = 8'h8E; e_dat[10] = 8'h80;
        e_n = (mask == 8'h00) ? 11 : 3;
    endtask

    // One complete run; poke issues a start request mid-run (R9)
    task automatic run(input logic [3:0] s, input logic [7:0] sec,
                       input logic [7:0] mask, input bit poke);
        int cyc;
        int d0;
        build_exp(s, sec, mask);
        log_n  = 0;
        m_ram0 = 8'h00;
        m_sec  = sec;
        m_mask = mask;
        sel    = s;
        d0     = done_cnt;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        sel = ~s;
        cyc = 0;
        while (!done) begin
            @(negedge clk);
            cyc++;
            start_i = (poke && cyc == 100);
        end
        start_i = 1'b0;
        chk(present == (mask == 8'h00), "R8", "present at done", int'(present), int'(mask == 8'h00));
        chk(!busy, "R8", "busy at done", int'(busy), 0);
        @(negedge clk);
        chk(!done, "R8", "done width", int'(done), 0);
        repeat (30) @(negedge clk);
        chk(!busy && !ce, "R9", "idle after run", int'(busy), 0);
        chk(done_cnt - d0 == 1, "R9", "done pulses per run", done_cnt - d0, 1);
        chk(log_n == e_n, (mask == 8'h00) ? "R7" : "R4", "access count", log_n, e_n);
        for (int i = 0; i < e_n && i < log_n; i++) begin
            chk(log_cmd[i] == e_cmd[i], tag_of(i), "command", log_cmd[i], e_cmd[i]);
            chk(log_dat[i] == e_dat[i], tag_of(i), "data", log_dat[i], e_dat[i]);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] msk;
        void'($urandom(32'h1F3A_0C57));
        repeat (4) @(negedge clk);
        chk(!ce && !sclk && !doe, "R1", "serial pins in reset", {ce, sclk, doe}, 0);
        chk(!busy && !done && !present, "R1", "status in reset", {busy, done, present}, 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(!ce && !busy && !present, "R1", "idle after reset", {ce, busy, present}, 0);

        run(4'h0, 8'h80, 8'h00, 1'b0);   // halt bit set: written back as 0 (R7)
        run(4'hF, 8'h7F, 8'h00, 1'b0);   // other bits kept (R7, R10)
        run(4'h5, 8'hFF, 8'h00, 1'b1);   // start during busy (R9)
        run(4'h9, 8'h00, 8'h01, 1'b0);   // read-back off in bit 0 (R4)
        run(4'h3, 8'h59, 8'h80, 1'b1);   // read-back off in bit 7 (R4, R9)
        run(4'hC, 8'hA5, 8'h00, 1'b0);

        for (int k = 0; k < 16; k++) begin
            msk = ($urandom_range(0, 1) == 0) ? 8'h00 : 8'($urandom_range(1, 255));
            run(4'($urandom_range(0, 15)), 8'($urandom_range(0, 255)), msk,
                ($urandom_range(0, 3) == 0));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule